// File: doc/BRIEF.md
# Multi-Source Reset Generator

This block turns several independent reset causes into one system reset and one reset per power domain. The causes are an active-low board pin, a software request written through a small register port, an expiry pulse from a watchdog, and the return of power to a domain. The pin takes effect at once, without waiting for a clock. Its release is brought into the reference clock domain before the reset lets go. Every reset output stays asserted for a fixed stretch of reference-clock cycles after its last cause, so downstream logic always sees a clean, long pulse.

Each power domain reports whether it is powered and whether its flops keep their state while power is off. A system-level flag marks the moment of leaving sleep. When a domain comes back, it is reset only if its state was lost. A domain of normal flops always loses its state. On a sleep exit, every domain that returns is reset, whatever its flop type. A one-hot status register shows which cause fired last. Software clears it by writing ones, and a pin reset sets it to the hardware code.

Top module: `rst_hub`

## Requirements
- R1: While `ext_rst_n` is low, `sys_rst_n` and every `dom_rst_n` bit are low, with no clock edge needed.
- R2: After `ext_rst_n` rises, `sys_rst_n` is first seen high after the (HOLD+3)-th rising clock edge. Two edges go to synchronisation and HOLD+1 to the hold stretch.
- R3: A `wdog_expire` high at edge k drives `sys_rst_n` low after edge k, and it is released after edge k+HOLD+1. A further cause inside the stretch restarts it.
- R4: A write with `wr_addr`=0 and `wr_data[0]`=1 at edge k raises a request that acts at edge k+1. `sys_rst_n` is low from edge k+1 through edge k+HOLD+1. The request then clears itself, so one write gives exactly one pulse.
- R5: A domain whose `dom_retain` bit is 0 and whose `dom_pwr_on` bit is first seen high at edge k gets `dom_rst_n` low after edge k for HOLD+1 cycles. `sys_rst_n` and the other domains are unaffected.
- R6: When `sleep_exit` is high at the edge where a domain's power is first seen high, that domain is reset as in R5, even when its `dom_retain` bit is 1.
- R7: A domain with `dom_retain`=1 that powers up while `sleep_exit` is low keeps `dom_rst_n` high and leaves the status unchanged.
- R8: Every `dom_rst_n` bit is low whenever `sys_rst_n` is low.
- R9: `rst_cause` is one-hot or zero. Bit 0 is hardware pin, bit 1 is watchdog, bit 2 is software and bit 3 is domain wakeup. It is updated at the edge where the cause acts, and a pin reset sets it to 4'b0001.
- R10: When causes act at the same edge, `rst_cause` records only the highest: hardware, then watchdog, then software, then wakeup.
- R11: A write with `wr_addr`=1 clears each `rst_cause` bit set in `wr_data`. If a cause acts at the same edge, the new cause code is stored instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| ext_rst_n | input | 1 | Asynchronous active-low board reset pin |
| wdog_expire | input | 1 | Watchdog expiry pulse, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control (bit 0 soft reset), 1 = status clear |
| wr_data | input | 4 | Write data |
| dom_pwr_on | input | NDOM | 1 = domain is powered |
| dom_retain | input | NDOM | 1 = domain holds retention flops |
| sleep_exit | input | 1 | High while the system leaves sleep |
| sys_rst_n | output | 1 | System reset, active low |
| dom_rst_n | output | NDOM | Per-domain reset, active low |
| rst_cause | output | 4 | One-hot last-cause status |

## Verification
Each cause has a fixed latency. A watchdog pulse or a power-up changes the outputs at the very next edge. A software write acts one edge later, because it passes through the request flop. A pin release shows up only after HOLD+3 edges. A behavioural model in the bench records the edge index at which each cause acts and derives every output from those indices. The outputs are compared with the model on each falling edge, half a cycle after they change. Targeted checks count low cycles from the stimulus edge and compare them against the R2 to R5 windows. Extra checks cover same-edge collisions for priority and for clear-versus-set.

// File: rtl/rst_hub.sv
module rst_hub #(
  parameter int NDOM = 4,
  parameter int HOLD = 16
) (
  input  logic            clk,
  input  logic            ext_rst_n,
  input  logic            wdog_expire,
  input  logic            wr_en,
  input  logic            wr_addr,
  input  logic [3:0]      wr_data,
  input  logic [NDOM-1:0] dom_pwr_on,
  input  logic [NDOM-1:0] dom_retain,
  input  logic            sleep_exit,
  output logic            sys_rst_n,
  output logic [NDOM-1:0] dom_rst_n,
  output logic [3:0]      rst_cause
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HLD = CW'(HOLD);

  logic [1:0]      pin_sync;
  logic            sw_req;
  logic [CW-1:0]   sys_cnt;
  logic            sys_q;
  logic [NDOM-1:0] pwr_d;
  logic [NDOM-1:0] dom_q;

  wire hw_cause  = ~pin_sync[1];
  wire sys_cause = hw_cause | wdog_expire | sw_req;
  wire sw_wr     = wr_en & ~wr_addr & wr_data[0];
  wire clr_wr    = wr_en & wr_addr;
  wire [NDOM-1:0] wake = dom_pwr_on & ~pwr_d & (~dom_retain | {NDOM{sleep_exit}});

  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n) begin
      pin_sync  <= 2'b00;
      sw_req    <= 1'b0;
      sys_cnt   <= HLD;
      sys_q     <= 1'b0;
      rst_cause <= 4'b0001;
    end else begin
      pin_sync <= {pin_sync[0], 1'b1};
      sw_req   <= sw_wr;
      sys_q    <= ~sys_cause & (sys_cnt == '0);
      if (sys_cause)           sys_cnt <= HLD;
      else if (sys_cnt != '0)  sys_cnt <= sys_cnt - CW'(1);
      if (hw_cause)            rst_cause <= 4'b0001;
      else if (wdog_expire)    rst_cause <= 4'b0010;
      else if (sw_req)         rst_cause <= 4'b0100;
      else if (|wake)          rst_cause <= 4'b1000;
      else if (clr_wr)         rst_cause <= rst_cause & ~wr_data;
    end
  end

  always_ff @(posedge clk) pwr_d <= dom_pwr_on;

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge ext_rst_n) begin
      if (!ext_rst_n) begin
        cnt      <= HLD;
        dom_q[d] <= 1'b0;
      end else begin
        dom_q[d] <= ~wake[d] & (cnt == '0);
        if (wake[d])          cnt <= HLD;
        else if (cnt != '0)   cnt <= cnt - CW'(1);
      end
    end
  end

  assign sys_rst_n = sys_q;
  assign dom_rst_n = dom_q & {NDOM{sys_q}};
endmodule

// File: rtl/rst_hub_chk.sv
module rst_hub_chk #(
  parameter int NDOM = 4,
  parameter int HOLD = 16
) (
  input logic            clk,
  input logic            ext_rst_n,
  input logic            wdog_expire,
  input logic            wr_en,
  input logic            wr_addr,
  input logic [3:0]      wr_data,
  input logic [NDOM-1:0] dom_pwr_on,
  input logic [NDOM-1:0] dom_retain,
  input logic            sleep_exit,
  input logic            sys_rst_n,
  input logic [NDOM-1:0] dom_rst_n,
  input logic [3:0]      rst_cause
);
  localparam int LW = $clog2(HOLD + 1);
  logic [LW-1:0] low_run;

  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n)                  low_run <= '0;
    else if (sys_rst_n)              low_run <= '0;
    else if (low_run != LW'(HOLD))   low_run <= low_run + LW'(1);
  end

  p_pin_r1: assert property (@(posedge clk)
    !ext_rst_n |-> (!sys_rst_n && dom_rst_n == '0));

  p_min_hold_r2: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $rose(sys_rst_n) |-> low_run == LW'(HOLD));

  p_wdog_r3: assert property (@(posedge clk) disable iff (!ext_rst_n)
    wdog_expire |=> !sys_rst_n);

  p_soft_r4: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (wr_en && !wr_addr && wr_data[0]) |-> ##2 !sys_rst_n);

  p_status_onehot_r9: assert property (@(posedge clk) $onehot0(rst_cause));

  p_pin_status_r9: assert property (@(posedge clk)
    !ext_rst_n |-> rst_cause == 4'b0001);

  p_prio_r10: assert property (@(posedge clk) disable iff (!ext_rst_n)
    wdog_expire |=> (rst_cause == 4'b0010 || rst_cause == 4'b0001));

  p_clear_r11: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (wr_en && wr_addr && !wdog_expire && sys_rst_n &&
     $past(!(wr_en && !wr_addr && wr_data[0])) &&
     (dom_pwr_on & ~$past(dom_pwr_on)) == '0)
    |=> (rst_cause & $past(wr_data)) == 4'b0000);

  for (genvar i = 0; i < NDOM; i++) begin : g_p
    p_wake_normal_r5: assert property (@(posedge clk) disable iff (!ext_rst_n)
      ($rose(dom_pwr_on[i]) && !dom_retain[i]) |=> !dom_rst_n[i]);
    p_sleep_exit_r6: assert property (@(posedge clk) disable iff (!ext_rst_n)
      ($rose(dom_pwr_on[i]) && sleep_exit) |=> !dom_rst_n[i]);
    p_retain_kept_r7: assert property (@(posedge clk) disable iff (!ext_rst_n)
      ($rose(dom_pwr_on[i]) && dom_retain[i] && !sleep_exit && dom_rst_n[i])
      |=> (dom_rst_n[i] || !sys_rst_n));
  end
endmodule

bind rst_hub rst_hub_chk #(.NDOM(NDOM), .HOLD(HOLD)) chk_i (.*);

// File: tb/rst_hub_tb.sv
module rst_hub_tb_top;
  localparam int ND = 4;
  localparam int HOLD = 16;

  logic clk = 1'b0;
  logic ext_rst_n = 1'b1;
  logic wdog_expire = 1'b0;
  logic wr_en = 1'b0;
  logic wr_addr = 1'b0;
  logic [3:0] wr_data = 4'h0;
  logic [ND-1:0] dom_pwr_on = '1;
  logic [ND-1:0] dom_retain = 4'b1010;
  logic sleep_exit = 1'b0;
  logic sys_rst_n;
  logic [ND-1:0] dom_rst_n;
  logic [3:0] rst_cause;

  always #10 clk = ~clk;

  rst_hub #(.NDOM(ND), .HOLD(HOLD)) dut_i (.*);

  int checks = 0, fails = 0;
  string tag = "R9";
  bit live = 0;
  bit done = 0;

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // behavioural model: edge index at which each cause last acted
  int n = 0, last_sys = 0, rel = 0;
  int last_w[ND] = '{default: -1000};
  bit [3:0] m_st = 4'b0001;
  bit m_sw = 0;
  bit [ND-1:0] m_prev = '1;

  always @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n) begin
      rel = 0; last_sys = n; m_st = 4'b0001; m_sw = 0;
    end else begin
      bit hwc, swc;
      bit [ND-1:0] wk;
      n++;
      hwc = (rel < 2); rel++;
      swc = m_sw;
      m_sw = wr_en && !wr_addr && wr_data[0];
      wk = dom_pwr_on & ~m_prev & (~dom_retain | {ND{sleep_exit}});
      m_prev = dom_pwr_on;
      if (hwc || wdog_expire || swc) last_sys = n;
      for (int i = 0; i < ND; i++) if (wk[i]) last_w[i] = n;
      if (hwc)              m_st = 4'b0001;
      else if (wdog_expire) m_st = 4'b0010;
      else if (swc)         m_st = 4'b0100;
      else if (|wk)         m_st = 4'b1000;
      else if (wr_en && wr_addr) m_st = m_st & ~wr_data;
    end
  end

  always @(negedge clk) if (live && !done) begin
    bit es;
    bit [ND-1:0] ed;
    es = ext_rst_n && (n - last_sys >= HOLD + 1);
    for (int i = 0; i < ND; i++) ed[i] = es && (n - last_w[i] >= HOLD + 1);
    chk(tag, sys_rst_n, es);
    chk(tag, dom_rst_n, ed);
    chk(tag, rst_cause, m_st);
  end

  task automatic cyc(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wdog_pulse();
    wdog_expire = 1'b1; @(negedge clk); wdog_expire = 1'b0;
  endtask

  task automatic reg_wr(logic a, logic [3:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d; @(negedge clk); wr_en = 1'b0; wr_data = 4'h0;
  endtask

  task automatic count_low(int idx, output int k);
    k = 0;
    while (((idx < 0) ? !sys_rst_n : !dom_rst_n[idx]) && k < 200) begin
      k++; @(negedge clk);
    end
  endtask

  task automatic pwr_off(int i);
    dom_pwr_on[i] = 1'b0; cyc(3);
  endtask

  initial begin
    int k;
    logic [3:0] saved;
    #1 ext_rst_n = 1'b0;
    cyc(3);
    live = 1;
    chk("R9", rst_cause, 4'b0001);
    chk("R1", {sys_rst_n, dom_rst_n}, 0);
    tag = "R2";
    #2 ext_rst_n = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!sys_rst_n && k < 200);
    chk("R2", k, HOLD + 3);
    cyc(3);

    tag = "R11";
    reg_wr(1'b1, 4'hF);
    chk("R11", rst_cause, 4'b0000);

    tag = "R3";
    wdog_pulse();
    chk("R8", dom_rst_n, 0);
    count_low(-1, k);
    chk("R3", k, HOLD + 1);
    chk("R3", rst_cause, 4'b0010);
    cyc(4);
    wdog_pulse();
    cyc(4);
    wdog_pulse();
    count_low(-1, k);
    chk("R3", k, HOLD + 1);
    cyc(4);

    tag = "R4";
    reg_wr(1'b0, 4'h1);
    chk("R4", sys_rst_n, 1);
    @(negedge clk);
    count_low(-1, k);
    chk("R4", k, HOLD + 1);
    chk("R4", rst_cause, 4'b0100);
    cyc(20);
    chk("R4", sys_rst_n, 1);

    tag = "R5";
    pwr_off(0);
    dom_pwr_on[0] = 1'b1; @(negedge clk);
    chk("R5", {sys_rst_n, dom_rst_n[3:1]}, 4'b1111);
    count_low(0, k);
    chk("R5", k, HOLD + 1);
    chk("R5", rst_cause, 4'b1000);
    cyc(3);

    tag = "R7";
    reg_wr(1'b1, 4'h8);
    saved = rst_cause;
    pwr_off(1);
    dom_pwr_on[1] = 1'b1; cyc(3);
    chk("R7", dom_rst_n[1], 1);
    chk("R7", rst_cause, saved);

    tag = "R6";
    pwr_off(1);
    dom_pwr_on[1] = 1'b1; sleep_exit = 1'b1; @(negedge clk); sleep_exit = 1'b0;
    count_low(1, k);
    chk("R6", k, HOLD + 1);
    chk("R6", rst_cause, 4'b1000);
    cyc(3);

    tag = "R10";
    pwr_off(2);
    dom_pwr_on[2] = 1'b1; wdog_pulse();
    chk("R10", rst_cause, 4'b0010);
    chk("R10", dom_rst_n[2], 0);
    cyc(22);
    pwr_off(0);
    wr_en = 1'b1; wr_addr = 1'b0; wr_data = 4'h1; @(negedge clk);
    wr_en = 1'b0; wr_data = 4'h0; dom_pwr_on[0] = 1'b1; @(negedge clk);
    chk("R10", rst_cause, 4'b0100);
    cyc(22);

    tag = "R11";
    pwr_off(2);
    dom_pwr_on[2] = 1'b1; @(negedge clk);
    chk("R11", rst_cause, 4'b1000);
    cyc(20);
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = 4'h8; wdog_expire = 1'b1; @(negedge clk);
    wr_en = 1'b0; wr_data = 4'h0; wdog_expire = 1'b0;
    chk("R11", rst_cause, 4'b0010);
    cyc(22);

    tag = "R1";
    #2 ext_rst_n = 1'b0;
    #1 chk("R1", {sys_rst_n, dom_rst_n}, 0);
    chk("R9", rst_cause, 4'b0001);
    cyc(3);
    #2 ext_rst_n = 1'b1;
    tag = "R2";
    cyc(25);
    chk("R2", sys_rst_n, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule